// File: doc/BRIEF.md
# Burst-Locked Digital PLL Loop Filter

This block closes a digital phase-locked loop on the short run of alternating data bits that each video line carries. While a burst window is open it watches the sampled baseband stream. Every time two consecutive samples lie on opposite sides of a mid-level threshold, it notes where inside the nominal bit cell the crossing fell. It converts that position into a signed 8-bit phase error. The errors of a fixed number of crossings at the start of the burst are averaged.

When the burst window closes, the average drives a single-pole IIR low-pass filter, once per line. The filtered value is added to an unsigned 8-bit center-frequency trim word supplied by the host. The sum is clamped to the 8-bit range and registered as the control word for an external oscillator.

A host open-loop bit holds the filter at zero, so the output becomes the trim word alone. This lets the oscillator run free while its center frequency is aligned. Because the filter sits at zero, closing the loop again causes no phase step.

Top module: `dpll_burst_loop`

## Requirements
- R1: A synchronous active-high reset clears the filter state and the registered control output to 0.
- R2: A crossing is counted when two consecutive valid samples inside one burst window lie on different sides of the threshold MID, where a sample counts as high when it is >= MID. The crossing's phase is the cell position of the later sample. Cell positions are counted from 0 at the first valid sample of the burst, modulo 2**PHASE_W, and advance only on valid samples.
- R3: The signed 8-bit error of a crossing at position p is (p - 2**(PHASE_W-1)) shifted left by 8-PHASE_W. For PHASE_W=2, positions 0, 1, 2 and 3 give -128, -64, 0 and +64.
- R4: Only the first 2**AVG_LOG2 crossings of a burst are used. Their sum, shifted right arithmetically by AVG_LOG2, is the burst's phase estimate. Crossings after that window have no effect.
- R5: A burst that ends with fewer than 2**AVG_LOG2 crossings leaves the filter and the output unchanged.
- R6: When a burst window falls, the filter does one update using a 9-bit signed difference: y = y + ((x - y) >>> K). The shift is arithmetic and rounds toward minus infinity.
- R7: The control output is clamp(trim + y, 0, 255), with the trim word unsigned and y signed. It is registered one clock after its inputs.
- R8: While the open-loop bit is high, the filter is held at 0 and burst results are discarded. After the bit has been high for two clocks, the output equals the trim word.
- R9: After the loop closes, the first update starts from y = 0.
- R10: Between burst ends the filter state does not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| smp_vld_i | input | 1 | Sample strobe |
| smp_i | input | SMP_W | Unsigned baseband sample |
| burst_i | input | 1 | High during the per-line burst window |
| trim_i | input | 8 | Unsigned center-frequency trim word |
| open_i | input | 1 | Open-loop control, high for free-running operation |
| ctrl_o | output | 8 | Registered oscillator control word |

## Verification
The bench builds the block with PHASE_W=2, AVG_LOG2=2 and K=1. With four samples per cell, each crossing position maps to an error step of 64. A six-cell burst therefore fills the four-crossing window and leaves surplus crossings that must be ignored. A shift of one moves the filter halfway on every line, so a few bursts are enough to reach clamping at both ends of the output range. The same setting reaches the case where the floor rounding stalls the filter one step below its target. Bursts with gaps in the sample strobe, bursts too short to fill the window, and open-loop bursts are all driven.

// File: rtl/dpll_pkg.sv
package dpll_pkg;
  localparam int CW_W = 8;
  typedef logic signed [CW_W-1:0] phase_t;
  typedef logic [CW_W-1:0] ctrl_t;
endpackage

// File: rtl/dpll_edge_phase.sv
module dpll_edge_phase
  import dpll_pkg::*;
#(
  parameter int SMP_W    = 8,
  parameter int MID      = 128,
  parameter int PHASE_W  = 3,
  parameter int AVG_LOG2 = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             smp_vld_i,
  input  logic [SMP_W-1:0] smp_i,
  input  logic             burst_i,
  output phase_t           avg_o,
  output logic             avg_vld_o
);
  localparam int HALF  = 1 << (PHASE_W - 1);
  localparam int SHL   = CW_W - PHASE_W;
  localparam int SUM_W = CW_W + AVG_LOG2;
  localparam int CNT_W = AVG_LOG2 + 1;
  localparam logic [CNT_W-1:0] FULL = CNT_W'(1 << AVG_LOG2);

  logic [PHASE_W-1:0]     pos_q;
  logic                   prev_hi_q;
  logic                   have_prev_q;
  logic                   in_burst_q;
  logic signed [SUM_W-1:0] sum_q;
  logic [CNT_W-1:0]       cnt_q;
  logic                   cur_hi;
  logic                   crossing;
  phase_t                 err;

  always_comb begin
    cur_hi   = (smp_i >= SMP_W'(MID));
    crossing = smp_vld_i && burst_i && have_prev_q && (cur_hi != prev_hi_q);
    err      = phase_t'((CW_W'(pos_q) - CW_W'(HALF)) << SHL);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pos_q       <= '0;
      prev_hi_q   <= 1'b0;
      have_prev_q <= 1'b0;
      in_burst_q  <= 1'b0;
      sum_q       <= '0;
      cnt_q       <= '0;
      avg_o       <= '0;
      avg_vld_o   <= 1'b0;
    end else begin
      avg_vld_o  <= 1'b0;
      in_burst_q <= burst_i;
      if (burst_i && smp_vld_i) begin
        if (crossing && (cnt_q != FULL)) begin
          sum_q <= sum_q + SUM_W'(err);
          cnt_q <= cnt_q + 1'b1;
        end
        prev_hi_q   <= cur_hi;
        have_prev_q <= 1'b1;
        pos_q       <= pos_q + 1'b1;
      end
      if (!burst_i && in_burst_q) begin
        avg_vld_o   <= (cnt_q == FULL);
        avg_o       <= phase_t'(sum_q >>> AVG_LOG2);
        sum_q       <= '0;
        cnt_q       <= '0;
        have_prev_q <= 1'b0;
        pos_q       <= '0;
      end
    end
  end
endmodule

// File: rtl/dpll_iir.sv
module dpll_iir
  import dpll_pkg::*;
#(
  parameter int K = 2
) (
  input  logic   clk,
  input  logic   rst,
  input  logic   hold_zero_i,
  input  logic   upd_i,
  input  phase_t x_i,
  output phase_t y_o
);
  logic signed [CW_W:0] diff;
  logic signed [CW_W:0] step;
  logic signed [CW_W:0] nxt;

  always_comb begin
    diff = {x_i[CW_W-1], x_i} - {y_o[CW_W-1], y_o};
    step = diff >>> K;
    nxt  = {y_o[CW_W-1], y_o} + step;
  end

  always_ff @(posedge clk) begin
    if (rst || hold_zero_i) y_o <= '0;
    else if (upd_i)         y_o <= phase_t'(nxt[CW_W-1:0]);
  end
endmodule

// File: rtl/dpll_trim_sat.sv
module dpll_trim_sat
  import dpll_pkg::*;
(
  input  logic   clk,
  input  logic   rst,
  input  ctrl_t  trim_i,
  input  phase_t y_i,
  output ctrl_t  ctrl_o
);
  localparam int SW = CW_W + 2;
  localparam logic signed [SW-1:0] TOP = SW'((1 << CW_W) - 1);

  logic signed [SW-1:0] total;

  always_comb total = $signed({2'b00, trim_i}) + $signed({{2{y_i[CW_W-1]}}, y_i});

  always_ff @(posedge clk) begin
    if (rst)              ctrl_o <= '0;
    else if (total < 0)   ctrl_o <= '0;
    else if (total > TOP) ctrl_o <= '1;
    else                  ctrl_o <= total[CW_W-1:0];
  end
endmodule

// File: rtl/dpll_burst_loop.sv
module dpll_burst_loop
  import dpll_pkg::*;
#(
  parameter int SMP_W    = 8,
  parameter int MID      = 1 << (SMP_W - 1),
  parameter int PHASE_W  = 3,
  parameter int AVG_LOG2 = 3,
  parameter int K        = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             smp_vld_i,
  input  logic [SMP_W-1:0] smp_i,
  input  logic             burst_i,
  input  logic [7:0]       trim_i,
  input  logic             open_i,
  output logic [7:0]       ctrl_o
);
  phase_t avg;
  logic   avg_vld;
  phase_t y;

  dpll_edge_phase #(
    .SMP_W(SMP_W), .MID(MID), .PHASE_W(PHASE_W), .AVG_LOG2(AVG_LOG2)
  ) u_edge (
    .clk(clk), .rst(rst), .smp_vld_i(smp_vld_i), .smp_i(smp_i),
    .burst_i(burst_i), .avg_o(avg), .avg_vld_o(avg_vld)
  );

  dpll_iir #(.K(K)) u_iir (
    .clk(clk), .rst(rst), .hold_zero_i(open_i), .upd_i(avg_vld),
    .x_i(avg), .y_o(y)
  );

  dpll_trim_sat u_sat (
    .clk(clk), .rst(rst), .trim_i(trim_i), .y_i(y), .ctrl_o(ctrl_o)
  );
endmodule

// File: rtl/dpll_burst_loop_chk.sv
module dpll_burst_loop_chk (
  input logic              clk,
  input logic              rst,
  input logic              open_i,
  input logic [7:0]        trim_i,
  input logic [7:0]        ctrl_o,
  input logic signed [7:0] y,
  input logic signed [7:0] avg,
  input logic              avg_vld
);
  p_reset_zero_r1: assert property (@(posedge clk)
    $past(rst) |-> (ctrl_o == 8'd0 && y == 8'sd0));

  p_hold_r10: assert property (@(posedge clk) disable iff (rst)
    (!avg_vld && !open_i) |=> $stable(y));

  p_open_zero_r8: assert property (@(posedge clk) disable iff (rst)
    open_i |=> (y == 8'sd0));

  p_open_out_r8: assert property (@(posedge clk) disable iff (rst)
    (open_i && $past(open_i)) |=> (ctrl_o == $past(trim_i)));

  p_step_up_r6: assert property (@(posedge clk) disable iff (rst)
    (avg_vld && !open_i && avg >= y) |=> (y >= $past(y) && y <= $past(avg)));

  p_step_dn_r6: assert property (@(posedge clk) disable iff (rst)
    (avg_vld && !open_i && avg < y) |=> (y <= $past(y) && y >= $past(avg)));
endmodule

bind dpll_burst_loop dpll_burst_loop_chk u_chk (
  .clk(clk), .rst(rst), .open_i(open_i), .trim_i(trim_i), .ctrl_o(ctrl_o),
  .y(y), .avg(avg), .avg_vld(avg_vld)
);

// File: tb/test_dpll_burst_loop.sv
module test_dpll_burst_loop;
  localparam int SPB = 4;
  localparam int NV  = 17;
  // {trim[18:11], phase[10:9], open[8], expected ctrl[7:0]}
  localparam logic [18:0] VEC [NV] = '{
    {8'd128, 2'd3, 1'b0, 8'd160}, {8'd128, 2'd3, 1'b0, 8'd176},
    {8'd100, 2'd1, 1'b0, 8'd92},  {8'd100, 2'd0, 1'b0, 8'd32},
    {8'd20,  2'd0, 1'b0, 8'd0},   {8'd20,  2'd2, 1'b0, 8'd0},
    {8'd60,  2'd2, 1'b0, 8'd35},  {8'd250, 2'd3, 1'b0, 8'd255},
    {8'd250, 2'd3, 1'b0, 8'd255}, {8'd77,  2'd3, 1'b1, 8'd77},
    {8'd77,  2'd3, 1'b0, 8'd109}, {8'd200, 2'd1, 1'b0, 8'd184},
    {8'd10,  2'd2, 1'b0, 8'd2},   {8'd10,  2'd2, 1'b0, 8'd6},
    {8'd10,  2'd2, 1'b0, 8'd8},   {8'd10,  2'd2, 1'b0, 8'd9},
    {8'd10,  2'd2, 1'b0, 8'd9}
  };

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       smp_vld_i = 1'b0;
  logic [7:0] smp_i = 8'd0;
  logic       burst_i = 1'b0;
  logic [7:0] trim_i = 8'd0;
  logic       open_i = 1'b0;
  logic [7:0] ctrl_o;
  int n_run = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  dpll_burst_loop #(.SMP_W(8), .PHASE_W(2), .AVG_LOG2(2), .K(1)) i_dpll_burst_loop (
    .clk(clk), .rst(rst), .smp_vld_i(smp_vld_i), .smp_i(smp_i),
    .burst_i(burst_i), .trim_i(trim_i), .open_i(open_i), .ctrl_o(ctrl_o)
  );

  task automatic chk(input string tag, input logic [7:0] exp);
    n_run++;
    if (ctrl_o !== exp) begin
      n_bad++;
      $display("FAIL %s: ctrl_o=%0d expected %0d", tag, ctrl_o, exp);
    end
  endtask

  task automatic burst(input int ph[6], input int ncells, input bit gaps);
    for (int c = 0; c < ncells; c++) begin
      for (int s = 0; s < SPB; s++) begin
        @(negedge clk);
        burst_i   = 1'b1;
        smp_vld_i = 1'b1;
        smp_i     = (((c + ((s >= ph[c]) ? 1 : 0)) % 2) == 1) ? 8'd200 : 8'd50;
        if (gaps) begin
          @(negedge clk);
          smp_vld_i = 1'b0;
        end
      end
    end
    @(negedge clk);
    smp_vld_i = 1'b0;
    burst_i   = 1'b0;
    repeat (6) @(negedge clk);
  endtask

  initial begin
    int ph[6];
    repeat (3) @(negedge clk);
    chk("R1 reset", 8'd0);
    trim_i = 8'd33;
    @(negedge clk);
    chk("R1 reset holds output", 8'd0);
    rst = 1'b0;
    repeat (3) @(negedge clk);
    chk("R7 trim with zero filter", 8'd33);

    // R2 R3 R6 R7 R8 R9: table of uniform-phase bursts
    for (int v = 0; v < NV; v++) begin
      @(negedge clk);
      trim_i = VEC[v][18:11];
      open_i = VEC[v][8];
      for (int c = 0; c < 6; c++) ph[c] = int'(VEC[v][10:9]);
      burst(ph, 6, 1'b0);
      chk($sformatf("R6/R7/R8 vector %0d", v), VEC[v][7:0]);
    end

    // R5: three crossings only, no update
    ph = '{3, 3, 3, 3, 3, 3};
    burst(ph, 3, 1'b0);
    chk("R5 short burst ignored", 8'd9);

    // R10: idle cycles keep the state
    repeat (20) @(negedge clk);
    chk("R10 hold between bursts", 8'd9);

    // R8: open clears the filter, output follows trim
    open_i = 1'b1;
    trim_i = 8'd100;
    repeat (3) @(negedge clk);
    chk("R8 open output equals trim", 8'd100);
    open_i = 1'b0;
    repeat (2) @(negedge clk);
    chk("R9 closed loop resumes at zero", 8'd100);

    // R4: crossings beyond the window are ignored
    ph = '{2, 2, 2, 2, 3, 3};
    burst(ph, 6, 1'b0);
    chk("R4 late crossings ignored", 8'd100);

    // R4: mixed phases averaged: (64*3+0)/4=48, y=24
    ph = '{3, 3, 3, 2, 1, 1};
    burst(ph, 6, 1'b0);
    chk("R4 mixed average positive", 8'd124);

    // R2: gapped strobe, (-64*3-128)/4=-80, y=24-52=-28
    ph = '{1, 1, 1, 0, 3, 3};
    burst(ph, 6, 1'b1);
    chk("R2 gapped samples mixed negative", 8'd72);

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_run++;
      n_bad++;
      $display("FAIL watchdog: run did not complete");
      $display("[TB] %0d tests run, %0d failed", n_run, n_bad);
      $finish;
    end
  end
endmodule